// File: doc/BRIEF.md
# One-to-Many Token Broadcast Manager

This block connects one token producer to several consumers over a send/acknowledge handshake. The producer raises `src_send` with a payload and keeps both steady until it sees `src_ack`. Each consumer sees its own send line. That line is high only while the producer is sending and that consumer has not yet taken the current token. Consumers therefore accept the same token in whatever cycles suit them, and none is offered the token twice.

One flag bit per consumer records that the consumer has taken the token. The combined acknowledge goes back to the producer in the cycle where every consumer has either taken the token earlier or is taking it now. In that same cycle all flags clear, so the next token starts with every consumer pending. The payload is a shared wire and is never registered.

The fan-out is a parameter. With a fan-out of one, the block reduces to a direct pass-through of send and acknowledge and holds no storage.

Top module: `token_bcast`

## Requirements
- R1: After a synchronous active-high reset, no consumer is marked as having taken a token: with `src_send` high, every bit of `dst_send` is 1.
- R2: `dst_send[i]` is 1 exactly when `src_send` is 1 and consumer i has not taken the current token.
- R3: Once consumer i has taken a token (`dst_ack[i]` high while `dst_send[i]` high), `dst_send[i]` stays 0 until `src_ack` has been given for that token.
- R4: `src_ack` is 1 only in a cycle where `src_send` is 1 and every consumer has taken the token, either in an earlier cycle or in the current one.
- R5: If all consumers acknowledge in the same cycle that a token is first offered, `src_ack` is 1 in that same cycle.
- R6: In the cycle after `src_ack`, all consumers are pending again: `dst_send` equals `src_send` replicated N times.
- R7: A `dst_ack[i]` given while `dst_send[i]` is 0 is ignored. This covers a consumer that has already taken the token and any cycle where `src_send` is 0. Such an ack neither marks the consumer nor completes a token.
- R8: `dst_data` equals `src_data` in the same cycle, whatever the handshake state.
- R9: With N=1, `dst_send` equals `src_send` and `src_ack` equals `src_send & dst_ack` in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_send | input | 1 | Producer has a token to offer |
| src_data | input | DW | Producer payload |
| src_ack | output | 1 | Token taken by all consumers |
| dst_send | output | N | Per-consumer qualified send |
| dst_data | output | DW | Shared payload to all consumers |
| dst_ack | input | N | Per-consumer take strobe |

## Verification
The bench targets a few corner cases, each with the failure it would expose:
- **Staggered acks.** Consumers take the token across several cycles, with the last one completing the token. A design that registers the final acknowledge would answer a cycle late. A design without per-consumer flags would re-offer tokens that were already taken.
- **Stray acks.** Acks arrive from consumers that were not offered the token, and while the producer is idle. A design that failed to qualify them would complete a token that some consumer never saw.
- **All consumers in one cycle.** Every consumer acks in the cycle the token is first offered. This must give a one-cycle transfer.
- **Back-to-back tokens.** Tokens follow each other directly. A design that kept stale flags would hide the next token from some consumers.
- **Fan-out of one.** A separate instance checks that the block degenerates to plain wires.

// File: rtl/bcast_pkg.sv
package bcast_pkg;
  // True when every bit of a completion vector is set.
  function automatic logic all_set(input logic [63:0] v, input int unsigned n);
    logic r;
    r = 1'b1;
    for (int unsigned k = 0; k < 64; k++) begin
      if (k < n) r = r & v[k];
    end
    return r;
  endfunction
endpackage

// File: rtl/bcast_flag_bank.sv
module bcast_flag_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         src_send,
  input  logic [N-1:0] dst_ack,
  input  logic         clear,
  output logic [N-1:0] offer,
  output logic [N-1:0] done
);
  logic [N-1:0] taken_q;
  logic [N-1:0] take;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_cell
      assign offer[gi] = src_send & ~taken_q[gi];
      assign take[gi]  = offer[gi] & dst_ack[gi];
      assign done[gi]  = taken_q[gi] | take[gi];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clear) taken_q <= '0;
    else              taken_q <= taken_q | take;
  end

  // R3
  property flags_hold_chk;
    @(posedge clk) disable iff (rst) !clear |=> ((taken_q & $past(taken_q)) == $past(taken_q));
  endproperty
  flags_hold_a: assert property (flags_hold_chk);

  // R7
  property no_unoffered_mark_chk;
    @(posedge clk) disable iff (rst) 1'b1 |=> ((taken_q & ~$past(taken_q) & ~$past(offer)) == '0);
  endproperty
  no_unoffered_mark_a: assert property (no_unoffered_mark_chk);

  // R6
  property clear_empties_chk;
    @(posedge clk) disable iff (rst) clear |=> (taken_q == '0);
  endproperty
  clear_empties_a: assert property (clear_empties_chk);
endmodule

// File: rtl/bcast_ack_join.sv
module bcast_ack_join
  import bcast_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic         src_send,
  input  logic [N-1:0] done,
  output logic         ack
);
  localparam int unsigned W = 64;
  logic [W-1:0] wide;

  always_comb begin
    wide = '0;
    wide[N-1:0] = done;
    ack = src_send & all_set(wide, N);
  end
endmodule

// File: rtl/token_bcast.sv
module token_bcast #(
  parameter int unsigned N  = 4,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          src_send,
  input  logic [DW-1:0] src_data,
  output logic          src_ack,
  output logic [N-1:0]  dst_send,
  output logic [DW-1:0] dst_data,
  input  logic [N-1:0]  dst_ack
);
  assign dst_data = src_data;

  generate
    if (N == 1) begin : g_single
      assign dst_send = src_send;
      assign src_ack  = src_send & dst_ack[0];
    end else begin : g_multi
      logic [N-1:0] done;
      logic         ack_all;

      bcast_flag_bank #(.N(N)) flags_i (
        .clk(clk), .rst(rst), .src_send(src_send), .dst_ack(dst_ack),
        .clear(ack_all), .offer(dst_send), .done(done)
      );

      bcast_ack_join #(.N(N)) join_i (
        .src_send(src_send), .done(done), .ack(ack_all)
      );

      assign src_ack = ack_all;
    end
  endgenerate

  // R4
  property ack_needs_all_chk;
    @(posedge clk) disable iff (rst) src_ack |-> (src_send && ((dst_ack | ~dst_send) == '1));
  endproperty
  ack_needs_all_a: assert property (ack_needs_all_chk);

  // R6
  property rearm_after_ack_chk;
    @(posedge clk) disable iff (rst) src_ack |=> (dst_send == {N{src_send}});
  endproperty
  rearm_after_ack_a: assert property (rearm_after_ack_chk);

  // R2
  property idle_no_offer_chk;
    @(posedge clk) disable iff (rst) !src_send |-> (dst_send == '0);
  endproperty
  idle_no_offer_a: assert property (idle_no_offer_chk);
endmodule

// File: tb/token_bcast_tb_top.sv
module token_bcast_tb_top;
  localparam int unsigned N  = 4;
  localparam int unsigned DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          src_send = 1'b0;
  logic [DW-1:0] src_data = '0;
  logic [N-1:0]  dst_ack = '0;
  logic          src_ack;
  logic [N-1:0]  dst_send;
  logic [DW-1:0] dst_data;

  logic          s1_send = 1'b0;
  logic          s1_ack_in = 1'b0;
  logic          s1_ack;
  logic [0:0]    s1_dsend;
  logic [DW-1:0] s1_data;

  int total = 0;
  int bad = 0;
  logic [N-1:0] flags_m = '0;

  always #10 clk = ~clk;

  token_bcast #(.N(N), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .src_send(src_send), .src_data(src_data),
    .src_ack(src_ack), .dst_send(dst_send), .dst_data(dst_data), .dst_ack(dst_ack)
  );

  token_bcast #(.N(1), .DW(DW)) dut_one_i (
    .clk(clk), .rst(rst), .src_send(s1_send), .src_data(src_data),
    .src_ack(s1_ack), .dst_send(s1_dsend), .dst_data(s1_data), .dst_ack(s1_ack_in)
  );

  function automatic logic [N-1:0] exp_offer(input logic s, input logic [N-1:0] f);
    return s ? ~f : '0;
  endfunction

  function automatic logic exp_ack(input logic s, input logic [N-1:0] f, input logic [N-1:0] a);
    return s && ((f | (exp_offer(s, f) & a)) == '1);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check combinational outputs, update model at posedge.
  task automatic step(input logic s, input logic [N-1:0] a, input logic [DW-1:0] d, input string req);
    logic [N-1:0] eo;
    logic ea;
    @(negedge clk);
    src_send = s; dst_ack = a; src_data = d;
    s1_send = s; s1_ack_in = a[0];
    #3;
    eo = exp_offer(s, flags_m);
    ea = exp_ack(s, flags_m, a);
    chk(dst_send === eo, {req, " R2 dst_send"}, 32'(dst_send), 32'(eo));
    chk(src_ack === ea, {req, " R4 src_ack"}, 32'(src_ack), 32'(ea));
    chk(dst_data === d, "R8 data", 32'(dst_data), 32'(d));
    chk(s1_dsend[0] === s && s1_ack === (s & a[0]), "R9 single",
        {30'd0, s1_dsend[0], s1_ack}, {30'd0, s, s & a[0]});
    @(posedge clk);
    flags_m = ea ? '0 : (flags_m | (eo & a));
  endtask

  initial begin
    #4000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state, everything offered
    step(1'b1, 4'b0000, 16'hA5A5, "R1");
    chk(flags_m == '0, "R1 model", 32'(flags_m), 0);
    // R3: staggered takes, then stray ack from consumed target
    step(1'b1, 4'b0001, 16'hA5A5, "R3");
    step(1'b1, 4'b0011, 16'hA5A5, "R3");   // bit0 ack again is ignored
    step(1'b1, 4'b0100, 16'hA5A5, "R3");
    step(1'b1, 4'b1000, 16'hA5A5, "R3");   // completes
    // R6: next token all pending
    step(1'b1, 4'b0000, 16'h1111, "R6");
    chk(dst_send == 4'b1111, "R6 rearm", 32'(dst_send), 32'hF);
    // R5: all in one cycle
    step(1'b1, 4'b1111, 16'h1111, "R5");
    step(1'b1, 4'b1111, 16'h2222, "R5");
    // R7: acks with send low are ignored
    step(1'b0, 4'b1111, 16'h3333, "R7");
    step(1'b1, 4'b0000, 16'h3333, "R7");
    chk(dst_send == 4'b1111 && src_ack == 1'b0, "R7 not marked", 32'(dst_send), 32'hF);
    step(1'b1, 4'b1111, 16'h3333, "R7");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic s;
      logic [N-1:0] a;
      s = ($urandom % 10) < 7;
      if (flags_m != '0) s = 1'b1;
      a = N'($urandom);
      step(s, a, (flags_m == '0) ? DW'($urandom) : src_data, "RND");
    end
    // reset mid-token clears flags (R1)
    step(1'b1, 4'b0101, 16'h4444, "R1");
    @(negedge clk); rst = 1'b1; src_send = 1'b0; dst_ack = '0;
    @(posedge clk); flags_m = '0;
    @(negedge clk); rst = 1'b0;
    step(1'b1, 4'b0000, 16'h4444, "R1");
    chk(dst_send == 4'b1111, "R1 after reset", 32'(dst_send), 32'hF);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule